// File: doc/BRIEF.md
# Bit-Latched Addressed Memory Front-End

This block puts a small word memory behind two sticky buffers, one for the write word and one for the address. Each bit of either buffer is set by its own one-cycle strobe. A bit stays set until something clears that whole buffer. Bits may arrive on any cycles before the command that uses them, so an upstream source can deliver them piece by piece.

A write command copies the data buffer into the location named by the address buffer, then empties the data buffer. A read command fetches the addressed word and returns it one cycle later, together with a valid flag. Neither command touches the address buffer. Only the address-clear input or reset empties it. Reset also zeros every memory location.

Top module: `latched_mem_front`

## Requirements
- R1: While rst is high, and in the first cycle after it falls, rd_valid is 0. A read of any location after reset returns 0.
- R2: A pulse on bit i of din_set sets bit i of the data buffer. The bit stays set across later cycles without further pulses.
- R3: A pulse on bit i of addr_set sets bit i of the address buffer. Bits arriving on different cycles accumulate by OR.
- R4: addr_clr empties the address buffer. If addr_set is also pulsed in the same cycle, the newly set bits survive the clear.
- R5: wr writes the data buffer, OR-ed with any din_set bits in that same cycle, into the location given by the address buffer (bit 0 is the LSB, 16 locations).
- R6: After wr, the data buffer is empty. Bits set by din_set in the same cycle as wr are consumed by that write and are not retained.
- R7: rd causes rd_data to hold the word at the buffered address, with rd_valid high, exactly one cycle after rd. rd_valid is low in every other cycle.
- R8: Neither wr nor rd changes the address buffer.
- R9: When wr and rd are high together, both take place, and the read returns the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears memory and both buffers |
| din_set | input | DW | Per-bit set strobes for the data buffer |
| addr_set | input | AW | Per-bit set strobes for the address buffer |
| addr_clr | input | 1 | Empties the address buffer |
| wr | input | 1 | Write the data buffer to the buffered address |
| rd | input | 1 | Read the buffered address |
| rd_data | output | DW | Word returned by the last read |
| rd_valid | output | 1 | High for one cycle when rd_data carries a read result |

## Verification
A stale bit in the address buffer makes the next read or write hit the wrong location. This shows up at the first read of either the intended or the corrupted location, one cycle after that read is issued. A data buffer that fails to empty after a write merges old bits into the next stored word, which the next read of that word exposes. A broken read delay shows up immediately as rd_valid high in the wrong cycle.

// File: rtl/latched_mem_front.sv
module latched_mem_front #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] din_set,
  input  logic [AW-1:0] addr_set,
  input  logic          addr_clr,
  input  logic          wr,
  input  logic          rd,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] dbuf;
  logic [AW-1:0] abuf;
  logic [DW-1:0] mem [DEPTH];

  wire [DW-1:0] wr_word  = dbuf | din_set;
  wire [AW-1:0] abuf_nxt = (addr_clr ? '0 : abuf) | addr_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      dbuf     <= '0;
      abuf     <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      dbuf     <= wr ? '0 : wr_word;
      abuf     <= abuf_nxt;
      rd_valid <= rd;
      if (rd) rd_data <= mem[abuf];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (rst) mem[i] <= '0;
      else if (wr && abuf == AW'(i)) mem[i] <= wr_word;
    end
  end

  // R1
  rst_valid_chk: assert property (@(posedge clk) rst |=> !rd_valid);
  // R7
  rd_lat_chk: assert property (@(posedge clk) disable iff (rst) rd |=> rd_valid);
  // R7
  rd_quiet_chk: assert property (@(posedge clk) disable iff (rst) !rd |=> !rd_valid);
  // R6
  wr_clears_chk: assert property (@(posedge clk) disable iff (rst) wr |=> dbuf == '0);
  // R8
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!addr_clr && addr_set == '0) |=> $stable(abuf));
  // R2
  dbuf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (dbuf & $past(dbuf)) == $past(dbuf));
endmodule

// File: tb/latched_mem_front_test.sv
module latched_mem_front_test;
  localparam int DW = 8, AW = 4, N = 16;
  logic clk = 0, rst = 1;
  logic [DW-1:0] din_set = '0;
  logic [AW-1:0] addr_set = '0;
  logic addr_clr = 0, wr = 0, rd = 0;
  logic [DW-1:0] rd_data;
  logic rd_valid;
  int checks = 0, errors = 0;
  logic [DW-1:0] m [N];
  logic [DW-1:0] md;
  logic [AW-1:0] ma;
  bit done = 0;

  latched_mem_front #(.DW(DW), .AW(AW)) uut (.*);

  always #4 clk = ~clk;

  function automatic logic [DW-1:0] exp_word(input logic [AW-1:0] a);
    return m[a];
  endfunction

  task automatic chk(input string r, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic step(input logic [DW-1:0] ds, input logic [AW-1:0] as, input logic ac,
                      input logic w, input logic r);
    din_set = ds; addr_set = as; addr_clr = ac; wr = w; rd = r;
    @(posedge clk); #1;
    din_set = '0; addr_set = '0; addr_clr = 0; wr = 0; rd = 0;
    if (ac) ma = '0;
    ma |= as;
  endtask

  task automatic rd_chk(input string r, input logic [DW-1:0] exp);
    step('0, '0, 0, 0, 1);
    chk({r, " valid"}, {7'd0, rd_valid}, 8'd1);
    chk(r, rd_data, exp);
    @(posedge clk); #1;
    chk({r, " valid drop"}, {7'd0, rd_valid}, 8'd0);
  endtask

  task automatic set_addr(input logic [AW-1:0] a);
    step('0, a, 1, 0, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m[i] = '0;
    md = '0; ma = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid in reset", {7'd0, rd_valid}, 8'd0);
    rst = 0;
    @(posedge clk); #1;
    chk("R1 valid after reset", {7'd0, rd_valid}, 8'd0);
    set_addr(4'd9);
    rd_chk("R1 mem zero", 8'h00);

    // R2/R3: bits accumulate on different cycles
    set_addr(4'd0);
    step(8'h01, 4'b0010, 0, 0, 0);
    step(8'h80, '0, 0, 0, 0);
    step(8'h10, 4'b1000, 0, 0, 0);
    repeat (2) @(posedge clk); #1;
    step('0, '0, 0, 1, 0); m[10] = 8'h91;
    rd_chk("R2 R3 R5 accumulated word at 10", 8'h91);

    // R6: data buffer emptied, same-cycle bits consumed
    step(8'h04, '0, 0, 1, 0); m[10] = 8'h04;
    step('0, '0, 0, 1, 0); m[10] = 8'h00;
    rd_chk("R6 buffer empty after write", 8'h00);

    // R4: clear with simultaneous set
    step('0, 4'b0001, 1, 0, 0);
    step(8'h3C, '0, 0, 1, 0); m[1] = 8'h3C;
    rd_chk("R4 clear then set -> addr 1", 8'h3C);

    // R9: simultaneous wr/rd sees old value
    step(8'hA5, '0, 0, 1, 1); m[1] = 8'hA5;
    chk("R9 old value", rd_data, 8'h3C);
    rd_chk("R9 new value", 8'hA5);

    // R8: address unchanged across commands
    step(8'h77, '0, 0, 1, 0); m[1] = 8'h77;
    rd_chk("R8 address held", 8'h77);

    // random
    for (int k = 0; k < 300; k++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      int op;
      op = $urandom % 4;
      if (op == 0) begin
        a = AW'($urandom);
        set_addr(a);
      end else if (op == 1) begin
        d = DW'($urandom);
        step(d, '0, 0, 0, 0); md |= d;
      end else if (op == 2) begin
        d = DW'($urandom);
        step(d, '0, 0, 1, 0); m[ma] = md | d; md = '0;
      end else begin
        rd_chk("R5 R7 random read", exp_word(ma));
      end
    end

    rst = 1;
    @(posedge clk); #1;
    rst = 0; ma = '0; md = '0;
    set_addr(4'd1);
    rd_chk("R1 reset zeros memory", 8'h00);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial void'($urandom(32'd1234));
endmodule